// File: doc/BRIEF.md
# Variable-Latency Functional Unit Issue Controller

This block is the issue stage of an in-order pipeline that feeds four execution units: an integer/memory unit, a floating-point adder, a floating-point multiplier, and a floating-point divider. The adder and the multiplier are fully pipelined. The divider is unpipelined. Each cycle the block takes at most one decoded instruction, made of a valid flag, a unit selector and a destination tag. It either fires the issue strobe of the selected unit in that same cycle, or it raises a stall. While the stall is high, the upstream stage holds the instruction unchanged.

Results of the three pipelined units are padded to one common depth, so each of them reaches the shared write-back port a fixed number of cycles after issue. The divider holds one operation at a time. It captures the tag when the operation is accepted and counts down its latency. In the cycle its result is due, the divider owns the write-back port. Any pipelined issue that would land in that same cycle is held back by one cycle, so the port is never claimed twice.

A build-time option switches between two policies. In the first, later pipelined instructions may overtake a divide. In the second, the block keeps write-backs in program order: a pipelined instruction is held until its result can only land after the pending divide result.

Top module: `fu_issue_ctrl`

## Requirements
- R1: Unit selector encoding: 0 selects the integer unit, 1 the adder, 2 the multiplier and 3 the divider. When `in_valid` is high and `stall` is low, exactly bit `in_unit` of `issue_strb` is high in that same cycle. Otherwise all of `issue_strb` is low.
- R2: When `in_valid` is low, `stall` is low and no issue strobe fires.
- R3: A pipelined instruction (unit 0, 1 or 2) issued in cycle t shows `wb_valid` high with its tag in cycle t+PIPE_LAT, which is t+3 by default.
- R4: The pipelined units accept one instruction in every cycle, back to back, with no stall between them.
- R5: A divide issued in cycle t shows `wb_valid` high with the tag captured at issue in cycle t+DIV_LAT, which is t+8 by default.
- R6: From the cycle after a divide issues through the cycle of its write-back, a further divide raises `stall`. A divide may issue in the cycle after that write-back.
- R7: A pipelined instruction whose write-back would coincide with the divider's write-back raises `stall` for that cycle. This is the cycle DIV_LAT−PIPE_LAT after the divide issued. The instruction issues in the following cycle.
- R8: At most one result is presented on the write-back port in any cycle.
- R9: With ORDERED_WB=1, a pipelined instruction stalls while its write-back would come before or at the same time as the pending divide result. It issues in the first cycle in which its result lands after the divide result, so write-backs keep program order. With ORDERED_WB=0 (the default), such an instruction issues at once unless R7 applies.
- R10: Synchronous active-high `rst` clears every in-flight result and the divider's busy state. No result issued before reset appears afterwards, and a divide may issue in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is offered this cycle |
| in_unit | input | 2 | Target unit: 0 integer, 1 adder, 2 multiplier, 3 divider |
| in_tag | input | TAG_W | Destination tag carried to write-back |
| issue_strb | output | 4 | One-hot issue strobe per unit, indexed by unit code |
| stall | output | 1 | Offered instruction not accepted; hold it |
| wb_valid | output | 1 | A result claims the write-back port this cycle |
| wb_tag | output | TAG_W | Destination tag of that result |

## Verification
Issue strobes and `stall` are combinational in the cycle the instruction is offered. Pipelined results are due exactly PIPE_LAT cycles after their issue cycle, and divide results exactly DIV_LAT cycles after. The bench drives each cycle's inputs on the falling edge and samples every output one nanosecond later. Each table row therefore holds both the response to that row's instruction and the write-back owed by the row issued three cycles earlier, or eight cycles earlier for a divide. The directed checks count cycles after a divide to hit the single collision cycle and the last busy cycle. In the in-order variant they look for the first cycle in which a pipelined result can follow the divide.

// File: rtl/fu_issue_pkg.sv
package fu_issue_pkg;

    typedef enum logic [1:0] {
        UNIT_INT  = 2'd0,
        UNIT_FADD = 2'd1,
        UNIT_FMUL = 2'd2,
        UNIT_FDIV = 2'd3
    } unit_e;

    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = 2;

endpackage

// File: rtl/fu_result_pad.sv
// Fixed-depth delay line that pads pipelined results to the common
// write-back stage. One entry enters and one leaves every cycle.
module fu_result_pad #(
    parameter int DEPTH = 3,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag
);

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
    } pad_state_t;

    pad_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.vld[0] = in_valid;
        state_d.tag[0] = in_tag;
        for (int s = 1; s < DEPTH; s++) begin
            state_d.vld[s] = state_q.vld[s-1];
            state_d.tag[s] = state_q.tag[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld[DEPTH-1];
    assign out_tag   = state_q.tag[DEPTH-1];

endmodule

// File: rtl/fu_div_tracker.sv
// Occupancy tracker for the unpipelined divider: captures the tag at
// acceptance and counts the remaining cycles to its write-back.
module fu_div_tracker #(
    parameter int DIV_LAT = 8,
    parameter int TAG_W   = 4,
    parameter int CNT_W   = $clog2(DIV_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TAG_W-1:0] start_tag,
    output logic [CNT_W-1:0] remain,
    output logic             done,
    output logic [TAG_W-1:0] done_tag
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DIV_LAT);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [TAG_W-1:0] tag;
    } div_state_t;

    div_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d.cnt = LOAD_VAL;
            state_d.tag = start_tag;
        end else if (state_q.cnt != '0) begin
            state_d.cnt = state_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign remain   = state_q.cnt;
    assign done     = (state_q.cnt == ONE);
    assign done_tag = state_q.tag;

endmodule

// File: rtl/fu_issue_arb.sv
// Combinational issue decision: structural hazard on the divider,
// write-back slot collision and optional in-order completion hold.
module fu_issue_arb
    import fu_issue_pkg::*;
#(
    parameter int PIPE_LAT   = 3,
    parameter int CNT_W      = 4,
    parameter bit ORDERED_WB = 1'b0
) (
    input  logic                 in_valid,
    input  logic [UNIT_W-1:0]    in_unit,
    input  logic [CNT_W-1:0]     div_remain,
    output logic                 stall,
    output logic [NUM_UNITS-1:0] issue_strb
);

    localparam logic [CNT_W-1:0] LAT_C   = CNT_W'(PIPE_LAT);
    localparam logic [CNT_W-1:0] CLASH_C = CNT_W'(PIPE_LAT + 1);

    logic is_div;
    logic div_busy;
    logic slot_clash;
    logic order_hold;
    logic hazard;

    assign is_div     = (unit_e'(in_unit) == UNIT_FDIV);
    assign div_busy   = (div_remain != '0);
    assign slot_clash = (div_remain == CLASH_C);

    generate
        if (ORDERED_WB) begin : g_ordered
            assign order_hold = (div_remain > LAT_C);
        end else begin : g_pass
            assign order_hold = 1'b0;
        end
    endgenerate

    always_comb begin
        hazard = is_div ? div_busy : (slot_clash | order_hold);
        stall  = in_valid & hazard;
    end

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_strb
            assign issue_strb[u] = in_valid & ~hazard & (in_unit == UNIT_W'(u));
        end
    endgenerate

endmodule

// File: rtl/fu_issue_ctrl.sv
module fu_issue_ctrl
    import fu_issue_pkg::*;
#(
    parameter int PIPE_LAT   = 3,
    parameter int DIV_LAT    = 8,
    parameter int TAG_W      = 4,
    parameter bit ORDERED_WB = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_unit,
    input  logic [TAG_W-1:0]     in_tag,
    output logic [3:0]           issue_strb,
    output logic                 stall,
    output logic                 wb_valid,
    output logic [TAG_W-1:0]     wb_tag
);

    localparam int CNT_W = $clog2(DIV_LAT + 1);

    logic [CNT_W-1:0] div_remain;
    logic             div_done;
    logic [TAG_W-1:0] div_tag;
    logic             pad_valid;
    logic [TAG_W-1:0] pad_tag;
    logic             pipe_issue;

    fu_issue_arb #(
        .PIPE_LAT   (PIPE_LAT),
        .CNT_W      (CNT_W),
        .ORDERED_WB (ORDERED_WB)
    ) arb_i (
        .in_valid   (in_valid),
        .in_unit    (in_unit),
        .div_remain (div_remain),
        .stall      (stall),
        .issue_strb (issue_strb)
    );

    assign pipe_issue = issue_strb[UNIT_INT] | issue_strb[UNIT_FADD] | issue_strb[UNIT_FMUL];

    fu_result_pad #(
        .DEPTH (PIPE_LAT),
        .TAG_W (TAG_W)
    ) pad_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (pipe_issue),
        .in_tag    (in_tag),
        .out_valid (pad_valid),
        .out_tag   (pad_tag)
    );

    fu_div_tracker #(
        .DIV_LAT (DIV_LAT),
        .TAG_W   (TAG_W),
        .CNT_W   (CNT_W)
    ) div_i (
        .clk       (clk),
        .rst       (rst),
        .start     (issue_strb[UNIT_FDIV]),
        .start_tag (in_tag),
        .remain    (div_remain),
        .done      (div_done),
        .done_tag  (div_tag)
    );

    always_comb begin
        wb_valid = div_done | pad_valid;
        wb_tag   = div_done ? div_tag : pad_tag;
    end

endmodule

// File: rtl/fu_issue_ctrl_chk.sv
module fu_issue_ctrl_chk #(
    parameter int PIPE_LAT   = 3,
    parameter int DIV_LAT    = 8,
    parameter int CNT_W      = 4,
    parameter bit ORDERED_WB = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       issue_strb,
    input logic             wb_valid,
    input logic [CNT_W-1:0] div_remain,
    input logic             div_done,
    input logic             pad_valid
);

    localparam logic [CNT_W-1:0] LAT_C  = CNT_W'(PIPE_LAT);
    localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(DIV_LAT);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    p_onehot_issue_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_strb));

    p_div_loaded_r5: assert property (@(posedge clk) disable iff (rst)
        issue_strb[3] |=> (div_remain == LOAD_C));

    p_div_countdown_r5: assert property (@(posedge clk) disable iff (rst)
        (div_remain > ONE_C) |=> (div_remain == $past(div_remain) - ONE_C));

    p_div_no_reissue_r6: assert property (@(posedge clk) disable iff (rst)
        (div_remain != '0) |-> !issue_strb[3]);

    p_single_wb_r8: assert property (@(posedge clk) disable iff (rst)
        !(pad_valid && div_done));

    p_in_order_r9: assert property (@(posedge clk) disable iff (rst)
        (ORDERED_WB && (div_remain > LAT_C)) |-> (issue_strb[2:0] == 3'b000));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!wb_valid && (div_remain == '0)));

endmodule

bind fu_issue_ctrl fu_issue_ctrl_chk #(
    .PIPE_LAT   (PIPE_LAT),
    .DIV_LAT    (DIV_LAT),
    .CNT_W      (CNT_W),
    .ORDERED_WB (ORDERED_WB)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .issue_strb (issue_strb),
    .wb_valid   (wb_valid),
    .div_remain (div_remain),
    .div_done   (div_done),
    .pad_valid  (pad_valid)
);

// File: tb/fu_issue_ctrl_tb_top.sv
module fu_issue_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_unit = 2'd0;
    logic [3:0] in_tag = 4'h0;

    logic [3:0] issue_strb, blk_issue;
    logic       stall, blk_stall;
    logic       wb_valid, blk_wb_valid;
    logic [3:0] wb_tag, blk_wb_tag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fu_issue_ctrl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit), .in_tag(in_tag),
        .issue_strb(issue_strb), .stall(stall), .wb_valid(wb_valid), .wb_tag(wb_tag)
    );

    fu_issue_ctrl #(.ORDERED_WB(1'b1)) dut_blk_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit), .in_tag(in_tag),
        .issue_strb(blk_issue), .stall(blk_stall), .wb_valid(blk_wb_valid), .wb_tag(blk_wb_tag)
    );

    // row: valid, unit, tag | exp stall, exp issue, exp wb_valid, exp wb_tag
    localparam int NV = 23;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 2'd0, 4'h1, 1'b0, 4'b0001, 1'b0, 4'h0},  // R1 R4 int
        {1'b1, 2'd1, 4'h2, 1'b0, 4'b0010, 1'b0, 4'h0},  // R4 adder
        {1'b1, 2'd2, 4'h3, 1'b0, 4'b0100, 1'b0, 4'h0},  // R4 multiplier
        {1'b1, 2'd3, 4'h4, 1'b0, 4'b1000, 1'b1, 4'h1},  // divide, R3 wb tag1
        {1'b1, 2'd3, 4'h5, 1'b1, 4'b0000, 1'b1, 4'h2},  // R6 busy
        {1'b1, 2'd0, 4'h6, 1'b0, 4'b0001, 1'b1, 4'h3},  // passes divide
        {1'b0, 2'd0, 4'h0, 1'b0, 4'b0000, 1'b0, 4'h0},  // R2 idle
        {1'b1, 2'd2, 4'h7, 1'b0, 4'b0100, 1'b0, 4'h0},
        {1'b1, 2'd1, 4'h8, 1'b1, 4'b0000, 1'b1, 4'h6},  // R7 clash
        {1'b1, 2'd1, 4'h8, 1'b0, 4'b0010, 1'b0, 4'h0},  // R7 retry
        {1'b0, 2'd3, 4'h0, 1'b0, 4'b0000, 1'b1, 4'h7},  // R2
        {1'b1, 2'd3, 4'h9, 1'b1, 4'b0000, 1'b1, 4'h4},  // R6 last busy, R5 div wb
        {1'b1, 2'd3, 4'h9, 1'b0, 4'b1000, 1'b1, 4'h8},  // R6 free again
        {1'b1, 2'd0, 4'hA, 1'b0, 4'b0001, 1'b0, 4'h0},
        {1'b0, 2'd0, 4'h0, 1'b0, 4'b0000, 1'b0, 4'h0},
        {1'b0, 2'd0, 4'h0, 1'b0, 4'b0000, 1'b0, 4'h0},
        {1'b0, 2'd0, 4'h0, 1'b0, 4'b0000, 1'b1, 4'hA},
        {1'b1, 2'd1, 4'hB, 1'b1, 4'b0000, 1'b0, 4'h0},  // R7 clash
        {1'b1, 2'd1, 4'hB, 1'b0, 4'b0010, 1'b0, 4'h0},
        {1'b0, 2'd0, 4'h0, 1'b0, 4'b0000, 1'b0, 4'h0},
        {1'b0, 2'd0, 4'h0, 1'b0, 4'b0000, 1'b1, 4'h9},  // R5 R8
        {1'b0, 2'd0, 4'h0, 1'b0, 4'b0000, 1'b1, 4'hB},  // R3
        {1'b0, 2'd0, 4'h0, 1'b0, 4'b0000, 1'b0, 4'h0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] u, input logic [3:0] t);
        in_valid = v;
        in_unit  = u;
        in_tag   = t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset wb_valid", {7'd0, wb_valid}, 8'd0);
        check("R10 reset stall", {7'd0, stall}, 8'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16], VEC[i][15:14], VEC[i][13:10]);
            #1;
            check("R7 R6 R2 stall", {7'd0, stall}, {7'd0, VEC[i][9]});
            check("R1 issue_strb", {4'd0, issue_strb}, {4'd0, VEC[i][8:5]});
            check("R3 R5 R8 wb_valid", {7'd0, wb_valid}, {7'd0, VEC[i][4]});
            if (VEC[i][4])
                check("R3 R5 wb_tag", {4'd0, wb_tag}, {4'd0, VEC[i][3:0]});
            @(negedge clk);
        end

        // R10: reset with a divide and an integer op in flight
        drive(1'b1, 2'd3, 4'h5);
        #1 check("R10 div issue", {4'd0, issue_strb}, 8'h08);
        @(negedge clk);
        drive(1'b1, 2'd0, 4'h6);
        @(negedge clk);
        drive(1'b0, 2'd0, 4'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check("R10 cleared wb", {7'd0, wb_valid}, 8'd0);
        drive(1'b1, 2'd3, 4'h7);
        #1 check("R10 divide free after reset", {3'd0, stall, issue_strb}, 8'h08);
        @(negedge clk);
        drive(1'b0, 2'd0, 4'h0);
        for (int k = 1; k < 8; k++) begin
            #1 check("R10 R5 no stale result", {7'd0, wb_valid}, 8'd0);
            @(negedge clk);
        end
        #1 check("R5 divide lands at +8", {3'd0, wb_valid, wb_tag}, 8'h17);
        @(negedge clk);
        @(negedge clk);

        // R9: ordered write-back variant
        drive(1'b1, 2'd3, 4'hC);
        #1 check("R9 blk div issue", {4'd0, blk_issue}, 8'h08);
        @(negedge clk);
        drive(1'b1, 2'd0, 4'hD);
        #1 check("R9 default variant passes", {3'd0, stall, issue_strb}, 8'h01);
        for (int k = 1; k < 6; k++) begin
            #1 check("R9 blk held", {3'd0, blk_stall, blk_issue}, 8'h10);
            @(negedge clk);
        end
        #1 check("R9 blk issues when ordered", {3'd0, blk_stall, blk_issue}, 8'h01);
        @(negedge clk);
        drive(1'b0, 2'd0, 4'h0);
        @(negedge clk);
        #1 check("R9 blk div first", {3'd0, blk_wb_valid, blk_wb_tag}, 8'h1C);
        @(negedge clk);
        #1 check("R9 blk int after", {3'd0, blk_wb_valid, blk_wb_tag}, 8'h1D);
        @(negedge clk);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule